// File: doc/BRIEF.md
# Disk controller host status handshake

This block sits between a host processor and the rest of a floppy disk controller. The host sees two byte locations, chosen by an address bit. One is an eight-bit main status word that can be read at any moment. The other is a single data location. Command bytes are written into the data location, and result bytes are read back from it. Internally the block steps through three phases: collecting command bytes, running a stub execution engine, and presenting result bytes. The status word tells the host when the next byte may move and in which direction.

After every accepted data access, the ready flag is held low for a fixed number of clock cycles. The data-rate select picks that number. The direction flag is only shown while the ready flag is high. The block registers four drive seek-activity inputs into the status word. While any of them is set, read and write commands are turned away. A small table keyed by the first command byte sets how many command bytes to collect, whether an execution phase follows, and how many result bytes to return. An access made at the wrong moment is dropped and raises a sticky fault output.

Top module: `fdc_host_status`

## Requirements
- R1: After reset, the status word reads 0x80 (ready, host-to-controller direction, not busy, no execution, no drive seeking) and `overrun` is 0.
- R2: Status bit 7 (ready) drops in the cycle after each accepted data access, and after the end of an execution phase. It stays low for exactly DLY_R0, DLY_R1, DLY_R2 or DLY_R3 cycles when `rate_sel` is 0, 1, 2 or 3 (fastest to slowest rate). It is never set during an execution phase.
- R3: Status bit 6 (direction) is 1 only when ready is 1 and the block is presenting result bytes (controller to host). Otherwise it is 0.
- R4: The opcode is bits 4:0 of the first command byte, and bits 7:5 are ignored. Opcode 0x06 (read) and 0x05 (write) take 9 command bytes, an execution phase and 7 result bytes. Opcode 0x03 takes 3 command bytes and no results. Opcode 0x0F takes 3 command bytes and no results. Opcode 0x08 takes 1 command byte and 2 results. A command with no execution phase goes straight to results, or back to idle when it has no results.
- R5: Status bit 4 (busy) is set from the first accepted command byte until the last command byte of a command without results, or until the last result byte is read. For a normal command, result byte k (k from 0) equals the last command byte plus k, modulo 256.
- R6: An execution phase lasts EXEC_CYCLES cycles. Status bit 5 is 1 throughout it when `dma_mode` is 0, and always 0 when `dma_mode` is 1.
- R7: Status bits 3:0 show `seek_act` delayed by one clock. A first byte with opcode 0x06 or 0x05, accepted while any of these bits is set, skips the command. It gives a single result byte 0x40 and no execution phase.
- R8: A first byte whose opcode is not in the table gives a single result byte 0x80 and no execution phase.
- R9: A data access (`a0`=1) is ignored and sets `overrun` in any of these cases: ready is 0; the direction is wrong (a read while collecting, a write while presenting); or both strobes are high. `overrun` stays set until reset.
- R10: With `a0`=0, `dout` returns the status word, and strobes have no effect on any phase, count or flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 2 | Data-rate select for the ready hold-off |
| dma_mode | input | 1 | 1 when transfers use DMA (hides the execution flag) |
| seek_act | input | NUM_DRIVES | Per-drive seek activity |
| a0 | input | 1 | 0 selects the status word, 1 selects the data location |
| rd_stb | input | 1 | One-cycle read strobe |
| wr_stb | input | 1 | One-cycle write strobe |
| din | input | 8 | Write data from the host |
| dout | output | 8 | Read data to the host |
| msr | output | 8 | Main status word |
| overrun | output | 1 | Sticky fault flag for dropped accesses |

## Verification
A behavioural reference model runs beside the design, and the status word is compared every cycle. The command mix includes a one-byte command with results and a three-byte command without results. It also includes a nine-byte command with execution, run both without and with DMA. These tell apart the length decoding, the phase exits and the execution-flag masking. All four rate selects are used, so a wrong hold-off length shows up as a ready edge one cycle off. The bench also sends a read opcode while a drive seeks, an undefined opcode, early writes, wrong-direction reads and status reads during hold-off. These tell apart the rejection, invalid-opcode and ignore paths from the normal path.

// File: rtl/fdc_hs_pkg.sv
package fdc_hs_pkg;

   typedef enum logic [1:0] {
      PH_CMD  = 2'd0,
      PH_EXEC = 2'd1,
      PH_RES  = 2'd2
   } phase_e;

   typedef enum logic [1:0] {
      RM_NORMAL  = 2'd0,
      RM_INVALID = 2'd1,
      RM_REJECT  = 2'd2
   } rmode_e;

   typedef struct packed {
      logic       valid;
      logic       rw;
      logic       exec;
      logic [3:0] ncmd;
      logic [3:0] nres;
   } cmd_info_t;

   localparam logic [4:0] OP_READ    = 5'h06;
   localparam logic [4:0] OP_WRITE   = 5'h05;
   localparam logic [4:0] OP_SETUP   = 5'h03;
   localparam logic [4:0] OP_POSN    = 5'h0F;
   localparam logic [4:0] OP_QUERY   = 5'h08;

   localparam logic [7:0] RES_INVALID = 8'h80;
   localparam logic [7:0] RES_REJECT  = 8'h40;

endpackage

// File: rtl/fdc_hs_cmd_lut.sv
module fdc_hs_cmd_lut
   import fdc_hs_pkg::*;
(
   input  logic [4:0] opc,
   output cmd_info_t  info
);
   always_comb begin
      info = '0;
      unique case (opc)
         OP_READ, OP_WRITE: info = '{valid: 1'b1, rw: 1'b1, exec: 1'b1, ncmd: 4'd9, nres: 4'd7};
         OP_SETUP:          info = '{valid: 1'b1, rw: 1'b0, exec: 1'b0, ncmd: 4'd3, nres: 4'd0};
         OP_POSN:           info = '{valid: 1'b1, rw: 1'b0, exec: 1'b0, ncmd: 4'd3, nres: 4'd0};
         OP_QUERY:          info = '{valid: 1'b1, rw: 1'b0, exec: 1'b0, ncmd: 4'd1, nres: 4'd2};
         default:           info = '0;
      endcase
   end
endmodule

// File: rtl/fdc_hs_rdy_timer.sv
module fdc_hs_rdy_timer #(
   parameter int DLY_R0 = 12,
   parameter int DLY_R1 = 20,
   parameter int DLY_R2 = 24,
   parameter int DLY_R3 = 48
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [1:0] rate,
   output logic       expired
);
   localparam int MAX01 = (DLY_R0 > DLY_R1) ? DLY_R0 : DLY_R1;
   localparam int MAX23 = (DLY_R2 > DLY_R3) ? DLY_R2 : DLY_R3;
   localparam int DMAX  = (MAX01 > MAX23) ? MAX01 : MAX23;
   localparam int W     = $clog2(DMAX + 1);

   logic [W-1:0] cnt;
   logic [W-1:0] ld_val;

   always_comb begin
      unique case (rate)
         2'd0:    ld_val = W'(DLY_R0);
         2'd1:    ld_val = W'(DLY_R1);
         2'd2:    ld_val = W'(DLY_R2);
         default: ld_val = W'(DLY_R3);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= ld_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/fdc_hs_seq.sv
module fdc_hs_seq
   import fdc_hs_pkg::*;
#(
   parameter int EXEC_CYCLES = 20
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_acc,
   input  logic      rd_acc,
   input  logic [7:0] din,
   input  logic      any_seek,
   input  cmd_info_t info,
   output phase_e    phase,
   output logic      busy,
   output logic      exec_end,
   output logic [7:0] res_byte
);
   localparam int EW = $clog2(EXEC_CYCLES + 1);

   logic [3:0]    nbytes, need_c, need_r, ridx;
   logic          exec_q;
   logic [7:0]    last;
   rmode_e        rmode;
   logic [EW-1:0] ecnt;

   logic          fin_now, fin_exec;
   logic [3:0]    fin_nres;

   always_comb begin
      fin_now  = 1'b0;
      fin_exec = exec_q;
      fin_nres = need_r;
      if (phase == PH_CMD && wr_acc) begin
         if (nbytes == 4'd0) begin
            fin_exec = info.exec;
            fin_nres = info.nres;
            fin_now  = info.valid && !(info.rw && any_seek) && (info.ncmd == 4'd1);
         end else begin
            fin_now  = (nbytes + 4'd1 == need_c);
         end
      end
   end

   assign exec_end = (phase == PH_EXEC) && (ecnt == EW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_CMD;
         nbytes <= '0;
         need_c <= '0;
         need_r <= '0;
         ridx   <= '0;
         exec_q <= 1'b0;
         last   <= '0;
         rmode  <= RM_NORMAL;
         ecnt   <= '0;
      end else begin
         unique case (phase)
            PH_CMD: if (wr_acc) begin
               last <= din;
               if (nbytes == 4'd0 && !info.valid) begin
                  phase <= PH_RES; need_r <= 4'd1; ridx <= '0; rmode <= RM_INVALID;
               end else if (nbytes == 4'd0 && info.rw && any_seek) begin
                  phase <= PH_RES; need_r <= 4'd1; ridx <= '0; rmode <= RM_REJECT;
               end else if (fin_now) begin
                  nbytes <= '0;
                  need_r <= fin_nres;
                  rmode  <= RM_NORMAL;
                  ridx   <= '0;
                  if (fin_exec) begin
                     phase <= PH_EXEC;
                     ecnt  <= EW'(EXEC_CYCLES);
                  end else if (fin_nres != 4'd0) begin
                     phase <= PH_RES;
                  end
               end else if (nbytes == 4'd0) begin
                  need_c <= info.ncmd;
                  need_r <= info.nres;
                  exec_q <= info.exec;
                  nbytes <= 4'd1;
               end else begin
                  nbytes <= nbytes + 4'd1;
               end
            end
            PH_EXEC: begin
               if (exec_end) phase <= PH_RES;
               else          ecnt  <= ecnt - 1'b1;
            end
            PH_RES: if (rd_acc) begin
               if (ridx + 4'd1 == need_r) phase <= PH_CMD;
               else                       ridx  <= ridx + 4'd1;
            end
            default: phase <= PH_CMD;
         endcase
      end
   end

   assign busy = (phase != PH_CMD) || (nbytes != 4'd0);

   always_comb begin
      unique case (rmode)
         RM_INVALID: res_byte = RES_INVALID;
         RM_REJECT:  res_byte = RES_REJECT;
         default:    res_byte = last + {4'd0, ridx};
      endcase
   end
endmodule

// File: rtl/fdc_host_status.sv
module fdc_host_status
   import fdc_hs_pkg::*;
#(
   parameter int NUM_DRIVES  = 4,
   parameter int EXEC_CYCLES = 20,
   parameter int DLY_R0      = 12,
   parameter int DLY_R1      = 20,
   parameter int DLY_R2      = 24,
   parameter int DLY_R3      = 48
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            rate_sel,
   input  logic                  dma_mode,
   input  logic [NUM_DRIVES-1:0] seek_act,
   input  logic                  a0,
   input  logic                  rd_stb,
   input  logic                  wr_stb,
   input  logic [7:0]            din,
   output logic [7:0]            dout,
   output logic [7:0]            msr,
   output logic                  overrun
);
   if (NUM_DRIVES < 1 || NUM_DRIVES > 4) begin : g_bad_drives
      $error("NUM_DRIVES must lie in 1..4");
   end
   if (EXEC_CYCLES < 1) begin : g_bad_exec
      $error("EXEC_CYCLES must be at least 1");
   end
   if (DLY_R0 < 1 || DLY_R1 < 1 || DLY_R2 < 1 || DLY_R3 < 1) begin : g_bad_dly
      $error("every ready hold-off must be at least one cycle");
   end

   logic [NUM_DRIVES-1:0] seek_q;
   logic [3:0]            seek_bits;
   logic                  rdy_idle, rqm, wr_acc, rd_acc, bad_acc;
   logic                  busy, exec_end;
   logic [7:0]            res_byte;
   phase_e                phase;
   cmd_info_t             info;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seek_q <= '0;
      else        seek_q <= seek_act;
   end

   for (genvar d = 0; d < 4; d++) begin : g_seek
      if (d < NUM_DRIVES) begin : g_on
         assign seek_bits[d] = seek_q[d];
      end else begin : g_off
         assign seek_bits[d] = 1'b0;
      end
   end

   assign rqm     = rdy_idle && (phase != PH_EXEC);
   assign wr_acc  = a0 && wr_stb && !rd_stb && rqm && (phase == PH_CMD);
   assign rd_acc  = a0 && rd_stb && !wr_stb && rqm && (phase == PH_RES);
   assign bad_acc = a0 && (rd_stb || wr_stb) && !wr_acc && !rd_acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       overrun <= 1'b0;
      else if (bad_acc) overrun <= 1'b1;
   end

   fdc_hs_cmd_lut u_lut (
      .opc  (din[4:0]),
      .info (info)
   );

   fdc_hs_rdy_timer #(
      .DLY_R0 (DLY_R0), .DLY_R1 (DLY_R1), .DLY_R2 (DLY_R2), .DLY_R3 (DLY_R3)
   ) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (wr_acc || rd_acc || exec_end),
      .rate    (rate_sel),
      .expired (rdy_idle)
   );

   fdc_hs_seq #(.EXEC_CYCLES(EXEC_CYCLES)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_acc   (wr_acc),
      .rd_acc   (rd_acc),
      .din      (din),
      .any_seek (|seek_q),
      .info     (info),
      .phase    (phase),
      .busy     (busy),
      .exec_end (exec_end),
      .res_byte (res_byte)
   );

   assign msr  = {rqm, rqm && (phase == PH_RES), (phase == PH_EXEC) && !dma_mode, busy, seek_bits};
   assign dout = a0 ? res_byte : msr;
endmodule

// File: rtl/fdc_hs_chk.sv
module fdc_hs_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       a0,
   input logic       rd_stb,
   input logic       wr_stb,
   input logic       dma_mode,
   input logic [7:0] msr,
   input logic [7:0] dout,
   input logic       overrun
);
   logic acc_ok;
   assign acc_ok = a0 && msr[7] && ((wr_stb && !rd_stb && !msr[6]) || (rd_stb && !wr_stb && msr[6]));

   AST_RDY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      acc_ok |=> !msr[7]);                                                 // R2
   AST_DIR_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
      msr[6] |-> msr[7]);                                                  // R3
   AST_EXEC_NOT_RDY: assert property (@(posedge clk) disable iff (!rst_n)
      msr[5] |-> (!msr[7] && msr[4]));                                     // R6
   AST_EXEC_HIDDEN_DMA: assert property (@(posedge clk) disable iff (!rst_n)
      dma_mode |-> !msr[5]);                                               // R6
   AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);                                                // R9
   AST_STATUS_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!a0 && msr[7]) |=> msr[7]);                                         // R10
   AST_STATUS_ON_DOUT: assert property (@(posedge clk) disable iff (!rst_n)
      !a0 |-> (dout == msr));                                              // R10
endmodule

bind fdc_host_status fdc_hs_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .a0       (a0),
   .rd_stb   (rd_stb),
   .wr_stb   (wr_stb),
   .dma_mode (dma_mode),
   .msr      (msr),
   .dout     (dout),
   .overrun  (overrun)
);

// File: tb/fdc_host_status_test.sv
`timescale 1ns/1ps
module fdc_host_status_test;
   localparam int EXEC = 20;
   localparam int D0 = 12, D1 = 20, D2 = 24, D3 = 48;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] rate_sel = 2'd0;
   logic       dma_mode = 1'b0;
   logic [3:0] seek_act = 4'd0;
   logic       a0 = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
   logic [7:0] din = 8'd0;
   logic [7:0] dout, msr;
   logic       overrun;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   fdc_host_status #(
      .NUM_DRIVES(4), .EXEC_CYCLES(EXEC),
      .DLY_R0(D0), .DLY_R1(D1), .DLY_R2(D2), .DLY_R3(D3)
   ) uut (
      .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .dma_mode(dma_mode),
      .seek_act(seek_act), .a0(a0), .rd_stb(rd_stb), .wr_stb(wr_stb),
      .din(din), .dout(dout), .msr(msr), .overrun(overrun)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Reference model: phases 0 collect, 1 execute, 2 present
   int m_ph = 0, m_nb = 0, m_nc = 0, m_nr = 0, m_ri = 0, m_tc = 0, m_ec = 0;
   bit m_exq = 0, m_ovr = 0;
   logic [3:0] m_sq = 4'd0;

   function automatic int hold(input logic [1:0] r);
      case (r)
         2'd0: return D0;
         2'd1: return D1;
         2'd2: return D2;
         default: return D3;
      endcase
   endfunction

   // table from R4: returns ncmd, nres, exec flag, rw flag; ncmd=0 for undefined
   task automatic table_lookup(input logic [7:0] b, output int nc, output int nr, output bit ex, output bit rw);
      nc = 0; nr = 0; ex = 0; rw = 0;
      case (b[4:0])
         5'h06, 5'h05: begin nc = 9; nr = 7; ex = 1; rw = 1; end
         5'h03, 5'h0F: begin nc = 3; nr = 0; end
         5'h08:        begin nc = 1; nr = 2; end
         default: ;
      endcase
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph = 0; m_nb = 0; m_nc = 0; m_nr = 0; m_ri = 0; m_tc = 0; m_ec = 0;
         m_exq = 0; m_ovr = 0; m_sq = 4'd0;
      end else begin
         bit rdy, wacc, racc, xend, done;
         int nc, nr; bit ex, rw;
         rdy  = (m_tc == 0) && (m_ph != 1);
         wacc = a0 && wr_stb && !rd_stb && rdy && (m_ph == 0);
         racc = a0 && rd_stb && !wr_stb && rdy && (m_ph == 2);
         xend = (m_ph == 1) && (m_ec == 1);
         done = 0;
         if (a0 && (rd_stb || wr_stb) && !wacc && !racc) m_ovr = 1;
         if (wacc || racc || xend) m_tc = hold(rate_sel);
         else if (m_tc > 0) m_tc--;
         if (wacc) begin
            if (m_nb == 0) begin
               table_lookup(din, nc, nr, ex, rw);
               if (nc == 0 || (rw && m_sq != 0)) begin
                  m_ph = 2; m_nr = 1; m_ri = 0;
               end else begin
                  m_nc = nc; m_nr = nr; m_exq = ex;
                  if (nc == 1) done = 1; else m_nb = 1;
               end
            end else if (m_nb + 1 == m_nc) done = 1;
            else m_nb++;
            if (done) begin
               m_nb = 0; m_ri = 0;
               if (m_exq) begin m_ph = 1; m_ec = EXEC; end
               else if (m_nr != 0) m_ph = 2;
            end
         end else if (m_ph == 1) begin
            if (m_ec == 1) begin m_ph = 2; m_ri = 0; end
            else m_ec--;
         end else if (racc) begin
            if (m_ri + 1 == m_nr) m_ph = 0; else m_ri++;
         end
         m_sq = seek_act;
      end
   end

   // every-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         logic [7:0] e;
         bit r;
         r = (m_tc == 0) && (m_ph != 1);
         e = {r, r && (m_ph == 2), (m_ph == 1) && !dma_mode, (m_ph != 0) || (m_nb != 0), m_sq};
         if (msr[7] !== e[7])        chk(0, "R2 ready", msr, e);
         else if (msr[6] !== e[6])   chk(0, "R3 direction", msr, e);
         else if (msr[5] !== e[5])   chk(0, "R6 exec flag", msr, e);
         else if (msr[4] !== e[4])   chk(0, "R5 busy", msr, e);
         else if (msr[3:0] !== e[3:0]) chk(0, "R7 seek bits", msr, e);
         else                        chk(1, "R2", msr, e);
         chk(overrun === m_ovr, "R9 overrun", overrun, m_ovr);
         if (!a0) chk(dout === msr, "R10 status on dout", dout, msr);
      end
   end

   task automatic step(); @(posedge clk); #1; endtask

   task automatic host_wr(input logic [7:0] b);
      while (!(msr[7] && !msr[6])) step();
      a0 = 1; din = b; wr_stb = 1;
      step();
      wr_stb = 0;
   endtask

   task automatic host_rd(input logic [7:0] exp, input string req);
      while (!(msr[7] && msr[6])) step();
      a0 = 1;
      #0.1;
      chk(dout === exp, req, dout, exp);
      rd_stb = 1;
      step();
      rd_stb = 0;
   endtask

   task automatic wait_idle();
      while (!(msr[7] && !msr[4])) step();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(0, "R2 watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) step();
      rst_n = 1;
      step();
      chk(msr === 8'h80, "R1 reset status", msr, 8'h80);
      chk(overrun === 1'b0, "R1 reset overrun", overrun, 0);

      // R4/R5: one-byte command with two results, fastest rate
      rate_sel = 2'd0;
      host_wr(8'h08);
      host_rd(8'h08, "R5 result 0");
      host_rd(8'h09, "R5 result 1");
      wait_idle();

      // R4: three-byte command, no results, rate 2; busy after two bytes
      rate_sel = 2'd2;
      host_wr(8'h03); host_wr(8'hA1);
      chk(msr[4] === 1'b1, "R4 busy mid-command", msr[4], 1);
      host_wr(8'h22);
      step();
      chk(msr[4] === 1'b0 && msr[6] === 1'b0, "R4 no result phase", msr, 8'h00);

      // R2: exact hold length at rate 1
      rate_sel = 2'd1;
      wait_idle();
      host_wr(8'h0F);
      for (int i = 0; i < D1 - 1; i++) step();
      chk(msr[7] === 1'b0, "R2 still held", msr[7], 0);
      step();
      chk(msr[7] === 1'b1, "R2 released", msr[7], 1);
      host_wr(8'h01); host_wr(8'h02);
      wait_idle();

      // R6/R5: read with execution flag, no DMA, rate 3
      rate_sel = 2'd3; dma_mode = 0;
      host_wr(8'h06);
      for (int i = 1; i < 8; i++) host_wr(8'(i));
      host_wr(8'h30);
      step();
      chk(msr[5] === 1'b1, "R6 exec flag shown", msr, 8'h30);
      for (int k = 0; k < 7; k++) host_rd(8'h30 + 8'(k), "R5 read results");
      wait_idle();

      // R6: write with DMA, upper opcode bits ignored (R4)
      rate_sel = 2'd0; dma_mode = 1;
      host_wr(8'h45);
      for (int i = 1; i < 8; i++) host_wr(8'(i));
      host_wr(8'h7F);
      step();
      chk(msr[5] === 1'b0 && msr[4] === 1'b1, "R6 exec hidden with DMA", msr, 8'h10);
      for (int k = 0; k < 7; k++) host_rd(8'h7F + 8'(k), "R4 write results");
      wait_idle();
      dma_mode = 0;

      // R7: read rejected while a drive seeks
      seek_act = 4'b0100;
      step(); step();
      chk(msr[3:0] === 4'b0100, "R7 seek bits", msr[3:0], 4'b0100);
      host_wr(8'h06);
      host_rd(8'h40, "R7 reject byte");
      wait_idle();
      host_wr(8'h08);
      host_rd(8'h08, "R7 other command accepted");
      host_rd(8'h09, "R7 other command accepted");
      wait_idle();
      seek_act = 4'd0;

      // R8: undefined opcode
      host_wr(8'h1F);
      host_rd(8'h80, "R8 invalid byte");
      wait_idle();

      // R10: status reads during hold-off change nothing
      host_wr(8'h03);
      a0 = 0; rd_stb = 1; wr_stb = 1; step(); rd_stb = 0; wr_stb = 0; step();
      chk(overrun === 1'b0, "R10 status strobes no overrun", overrun, 0);
      host_wr(8'h11); host_wr(8'h12);
      step();
      chk(msr[4] === 1'b0, "R10 command count intact", msr[4], 0);

      // R9: early write, wrong direction read, both strobes
      wait_idle();
      host_wr(8'h08);
      a0 = 1; din = 8'h55; wr_stb = 1; step(); wr_stb = 0; step();
      chk(overrun === 1'b1, "R9 early access", overrun, 1);
      host_rd(8'h08, "R9 ignored write left results");
      host_rd(8'h09, "R9 ignored write left results");
      wait_idle();
      a0 = 1; rd_stb = 1; step(); rd_stb = 0;
      a0 = 1; rd_stb = 1; wr_stb = 1; step(); rd_stb = 0; wr_stb = 0; step();
      chk(msr === 8'h80 && overrun === 1'b1, "R9 ignored and sticky", msr, 8'h80);

      repeat (5) step();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule